// File: doc/BRIEF.md
# SPI Master Byte Shifter with Completion and Collision Flags

This block is a single-byte SPI master behind a small register window. Software writes a byte to the data register while the engine is idle and no completion is pending. The engine then divides the system clock into SCK and shifts the byte out on MOSI, most significant bit first. In the same eight SCK periods it gathers one byte from MISO. When the eighth SCK rising edge arrives, the engine raises a completion flag and moves the gathered byte into a read buffer. If the interrupt enable is set, it also raises an interrupt request.

Once a transfer has completed, software has to acknowledge it in two steps: first a read of the status register, then one access to the data register. Until that status read happens, the data register is locked. Reads of it return zero, writes to it are dropped, and the shifter ignores any further SCK activity. A data-register access made while a transfer is running sets a collision flag and has no other effect. The collision flag clears in the same acknowledge sequence as the completion flag.

The CPU side uses plain single-cycle read and write strobes with an address. The block moves no stream, so it has no valid/ready handshake and no back-pressure. Each strobe is accepted in the cycle it is high.

Top module: `spi_xfer_core`

Register addresses: 0 = control, 1 = status, 2 = data. Address 3 reads as zero.

## Requirements
- R1: Control bit 0 selects the SCK rate. When it is 1, the SCK period is 16 system clocks. When it is 0, the SCK period is 2 system clocks. Control bit 7 is the interrupt enable. The control register reads back as written and resets to 0x00.
- R2: A write to address 2 starts an 8-bit transfer if the engine is idle and the completion flag is clear. MOSI carries the written byte MSB first and changes only after SCK falls. SCK idles low.
- R3: MISO is sampled on each SCK rising edge, MSB first. On the eighth rising edge, the completion flag (status bit 7) sets and the sampled byte becomes the value that data-register reads return.
- R4: irq_o is high exactly while the completion flag is set and control bit 7 is 1. The collision flag never drives irq_o.
- R5: While the completion flag is set and no status read has been made since it set, reads of address 2 return 0x00. Writes to address 2 are ignored. No new transfer starts, so SCK stays low.
- R6: Two steps, in this order, clear both the completion flag and the collision flag. The first is a read of address 1 while the completion flag is set. The second is the next access to address 2. If that access is a read, it returns the received byte. If it is a write, it does not start a transfer.
- R7: A read of address 1 while the completion flag is clear does not count as the first step of the clearing sequence.
- R8: The engine counts as busy from the start of a transfer until SCK has returned low after the eighth pulse. Any access to address 2 while busy does four things:
  - it sets the collision flag (status bit 6);
  - if it is a read, it returns 0x00;
  - if it is a write, it leaves the shifted byte unchanged;
  - it does not stop the transfer.
  The collision flag is read-only: writes to address 1 have no effect on it.
- R9: Status bits 5 to 0 always read as zero. After reset, both flags and irq_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register, valid in the strobe cycle |
| sck_o | output | 1 | Serial clock, idle low |
| mosi_o | output | 1 | Serial data out, MSB first |
| miso_i | input | 1 | Serial data in, sampled on SCK rising edges |
| irq_o | output | 1 | Transfer-complete interrupt request |

## Verification
The checker assumes the following about the inputs:
- a read strobe and a write strobe never come in the same cycle;
- the address is stable while a strobe is high;
- MISO changes only after SCK falls, never at an SCK rising edge.

The stimulus keeps to these rules. Its bus tasks raise one strobe at a time for one cycle, changing it at the falling system-clock edge and leaving an idle cycle between accesses. Its slave model moves MISO only on SCK falling edges.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_DATA = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  localparam int CTRL_IRQ_BIT  = 7;
  localparam int CTRL_RATE_BIT = 0;
  localparam int STAT_DONE_BIT = 7;
  localparam int STAT_COLL_BIT = 6;
endpackage

// File: rtl/spi_sck_gen.sv
module spi_sck_gen #(
  parameter int DIV_FAST = 2,
  parameter int DIV_SLOW = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic slow,
  output logic tick
);
  localparam int HALF_F = DIV_FAST / 2;
  localparam int HALF_S = DIV_SLOW / 2;
  localparam int HALF_M = (HALF_S > HALF_F) ? HALF_S : HALF_F;
  localparam int CW     = (HALF_M > 1) ? $clog2(HALF_M) : 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] reload;

  // half-period length for the selected rate
  assign reload = slow ? CW'(HALF_S - 1) : CW'(HALF_F - 1);
  assign tick   = run && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= reload;
    else if (tick)   cnt <= reload;
    else             cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] load,
  input  logic         tick,
  input  logic         miso,
  output logic         sck,
  output logic         mosi,
  output logic         busy,
  output logic         last_rise,
  output logic [W-1:0] rx_word
);
  localparam int BW = $clog2(W + 1);

  logic [W-1:0]  tx_q;
  logic [W-1:0]  rx_q;
  logic [BW-1:0] nb_q;
  logic          sck_q;
  logic          busy_q;

  assign rx_word   = {rx_q[W-2:0], miso};
  assign last_rise = tick && !sck_q && (nb_q == BW'(W - 1));
  assign sck       = sck_q;
  assign mosi      = tx_q[W-1];
  assign busy      = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_q   <= '0;
      rx_q   <= '0;
      nb_q   <= '0;
      sck_q  <= 1'b0;
      busy_q <= 1'b0;
    end else if (start) begin
      tx_q   <= load;
      nb_q   <= '0;
      sck_q  <= 1'b0;
      busy_q <= 1'b1;
    end else if (tick) begin
      if (!sck_q) begin
        // rising edge: sample
        sck_q <= 1'b1;
        rx_q  <= rx_word;
        nb_q  <= nb_q + 1'b1;
      end else begin
        // falling edge: advance, or finish after the last pulse
        sck_q <= 1'b0;
        if (nb_q == BW'(W)) busy_q <= 1'b0;
        else                tx_q   <= {tx_q[W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/spi_flag_ctrl.sv
module spi_flag_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic stat_rd,
  input  logic data_acc,
  input  logic busy,
  input  logic last_rise,
  output logic done,
  output logic coll,
  output logic armed
);
  logic done_q, coll_q, armed_q;
  logic clr;

  assign clr   = data_acc && armed_q && done_q;
  assign done  = done_q;
  assign coll  = coll_q;
  assign armed = armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      coll_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (last_rise)  done_q <= 1'b1;
      else if (clr)   done_q <= 1'b0;

      // a data access during a transfer wins over a clear
      if (data_acc && busy) coll_q <= 1'b1;
      else if (clr)         coll_q <= 1'b0;

      if (clr)                   armed_q <= 1'b0;
      else if (stat_rd && done_q) armed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/spi_xfer_core.sv
module spi_xfer_core
  import spi_xfer_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DIV_FAST = 2,
  parameter int DIV_SLOW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              irq_o
);
  logic              irq_en_q, rate_q, rate_run_q;
  logic [DATA_W-1:0] rxbuf_q;
  logic              busy_w, tick_w, last_rise_w;
  logic              done_w, coll_w, armed_w;
  logic [DATA_W-1:0] rx_word_w;
  logic              data_acc, stat_rd, start, blocked;

  assign data_acc = (bus_rd || bus_wr) && (bus_addr == REG_DATA);
  assign stat_rd  = bus_rd && (bus_addr == REG_STAT);
  assign start    = bus_wr && (bus_addr == REG_DATA) && !busy_w && !done_w;
  assign blocked  = busy_w || (done_w && !armed_w);
  assign irq_o    = done_w && irq_en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_en_q   <= 1'b0;
      rate_q     <= 1'b0;
      rate_run_q <= 1'b0;
      rxbuf_q    <= '0;
    end else begin
      if (bus_wr && (bus_addr == REG_CTRL)) begin
        irq_en_q <= bus_wdata[CTRL_IRQ_BIT];
        rate_q   <= bus_wdata[CTRL_RATE_BIT];
      end
      if (start)       rate_run_q <= rate_q;
      if (last_rise_w) rxbuf_q    <= rx_word_w;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      REG_CTRL: begin
        bus_rdata[CTRL_IRQ_BIT]  = irq_en_q;
        bus_rdata[CTRL_RATE_BIT] = rate_q;
      end
      REG_STAT: begin
        bus_rdata[STAT_DONE_BIT] = done_w;
        bus_rdata[STAT_COLL_BIT] = coll_w;
      end
      REG_DATA: bus_rdata = blocked ? '0 : rxbuf_q;
      default:  bus_rdata = '0;
    endcase
  end

  spi_sck_gen #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) sck_gen_i (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy_w),
    .slow  (busy_w ? rate_run_q : rate_q),
    .tick  (tick_w)
  );

  spi_shifter #(.W(DATA_W)) shifter_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .load      (bus_wdata),
    .tick      (tick_w),
    .miso      (miso_i),
    .sck       (sck_o),
    .mosi      (mosi_o),
    .busy      (busy_w),
    .last_rise (last_rise_w),
    .rx_word   (rx_word_w)
  );

  spi_flag_ctrl flags_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .stat_rd   (stat_rd),
    .data_acc  (data_acc),
    .busy      (busy_w),
    .last_rise (last_rise_w),
    .done      (done_w),
    .coll      (coll_w),
    .armed     (armed_w)
  );
endmodule

// File: rtl/spi_xfer_core_chk.sv
module spi_xfer_core_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sck_o,
  input logic         mosi_o,
  input logic         irq_o,
  input logic         done,
  input logic         coll,
  input logic         armed,
  input logic         busy,
  input logic         bus_rd,
  input logic [1:0]   bus_addr,
  input logic [W-1:0] bus_rdata
);
  AST_DONE_ON_SCK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $rose(sck_o)); // R3
  AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> done); // R4
  AST_SCK_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck_o); // R2
  AST_CLEAR_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> $past(armed)); // R6
  AST_FROZEN_WHILE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done)) |-> $stable(mosi_o)); // R5
  AST_COLL_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(coll) |-> $past(busy)); // R8
  AST_STAT_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 2'd1) |-> (bus_rdata[5:0] == 6'd0)); // R9
endmodule

bind spi_xfer_core spi_xfer_core_chk #(.W(DATA_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .sck_o     (sck_o),
  .mosi_o    (mosi_o),
  .irq_o     (irq_o),
  .done      (done_w),
  .coll      (coll_w),
  .armed     (armed_w),
  .busy      (busy_w),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata)
);

// File: tb/spi_xfer_core_tb_top.sv
module spi_xfer_core_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       sck_o, mosi_o, irq_o;
  logic       miso_i = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  spi_xfer_core dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i), .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // scoreboard of bytes expected on MOSI
  logic [7:0] mosi_q[$];
  logic [7:0] mon_sh = 8'h00;
  int         mon_n = 0;
  int         sck_rises = 0;

  always @(posedge sck_o) begin
    mon_sh = {mon_sh[6:0], mosi_o};
    mon_n++;
    sck_rises++;
    if (mon_n == 8) begin
      mon_n = 0;
      if (mosi_q.size() == 0) chk(1'b0, "R2", "unexpected MOSI byte", int'(mon_sh), 0);
      else begin
        logic [7:0] e;
        e = mosi_q.pop_front();
        chk(mon_sh == e, "R2", "MOSI byte (R8 when collided)", int'(mon_sh), int'(e));
      end
    end
  end

  // slave model: shifts out on SCK falling edges
  logic [7:0] slv_sh = 8'h00;
  always @(negedge sck_o) begin
    slv_sh = {slv_sh[6:0], 1'b0};
    miso_i = slv_sh[7];
  end

  // SCK period measured in system clocks between rising edges
  int  ncount = 0;
  int  last_rise_n = 0;
  int  sck_period = 0;
  logic sck_prev = 1'b0;
  always @(negedge clk) begin
    ncount++;
    if (sck_o && !sck_prev) begin
      sck_period  = ncount - last_rise_n;
      last_rise_n = ncount;
    end
    sck_prev = sck_o;
  end

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic start_xfer(input logic [7:0] tx, input logic [7:0] slv);
    mosi_q.push_back(tx);
    slv_sh = slv;
    miso_i = slv[7];
    bus_write(2'd2, tx);
  endtask

  task automatic wait_xfer(input int target);
    while (!(sck_rises >= target && !sck_o)) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic [7:0] d;
    int rs;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    bus_read(2'd1, d); chk(d == 8'h00, "R9", "status after reset", int'(d), 0);
    bus_read(2'd0, d); chk(d == 8'h00, "R1", "control after reset", int'(d), 0);
    chk(irq_o == 1'b0 && sck_o == 1'b0, "R9", "irq/sck after reset",
        int'({irq_o, sck_o}), 0);

    // fast transfer with interrupt enabled
    bus_write(2'd0, 8'h80);
    bus_read(2'd0, d); chk(d == 8'h80, "R1", "control readback", int'(d), 8'h80);
    start_xfer(8'hA5, 8'h3C);
    wait_xfer(8);
    chk(sck_period == 2, "R1", "fast SCK period", sck_period, 2);
    chk(irq_o == 1'b1, "R4", "irq with enable", int'(irq_o), 1);
    bus_read(2'd1, d); chk(d == 8'h80, "R3", "done flag set", int'(d), 8'h80);
    bus_read(2'd2, d); chk(d == 8'h3C, "R6", "clearing read returns rx byte", int'(d), 8'h3C);
    bus_read(2'd1, d); chk(d == 8'h00, "R6", "flags cleared", int'(d), 0);
    chk(irq_o == 1'b0, "R4", "irq drops with done", int'(irq_o), 0);

    // slow transfer, interrupt disabled
    bus_write(2'd0, 8'h01);
    start_xfer(8'h96, 8'hC3);
    wait_xfer(16);
    chk(sck_period == 16, "R1", "slow SCK period", sck_period, 16);
    chk(irq_o == 1'b0, "R4", "no irq when disabled", int'(irq_o), 0);
    bus_read(2'd2, d); chk(d == 8'h00, "R5", "locked data read", int'(d), 0);
    rs = sck_rises;
    bus_write(2'd2, 8'hFF);
    repeat (20) @(negedge clk);
    chk(sck_rises == rs && sck_o == 1'b0, "R5", "locked write starts nothing", sck_rises, rs);
    bus_read(2'd1, d); chk(d == 8'h80, "R5", "done still set after locked accesses", int'(d), 8'h80);
    rs = sck_rises;
    bus_write(2'd2, 8'h11);
    repeat (20) @(negedge clk);
    chk(sck_rises == rs, "R6", "clearing write starts no transfer", sck_rises, rs);
    bus_read(2'd1, d); chk(d == 8'h00, "R6", "flags cleared by write", int'(d), 0);
    bus_read(2'd2, d); chk(d == 8'hC3, "R3", "rx buffer after slow transfer", int'(d), 8'hC3);

    // collision during a slow transfer with interrupt enabled
    bus_write(2'd0, 8'h81);
    start_xfer(8'h5A, 8'hA5);
    bus_write(2'd2, 8'hFF);
    bus_read(2'd2, d); chk(d == 8'h00, "R8", "read while busy", int'(d), 0);
    bus_read(2'd1, d); chk(d == 8'h40, "R8", "collision flag", int'(d), 8'h40);
    chk(irq_o == 1'b0, "R4", "collision gives no irq", int'(irq_o), 0);
    bus_write(2'd1, 8'h00);
    bus_read(2'd1, d); chk(d == 8'h40, "R8", "collision read-only", int'(d), 8'h40);
    wait_xfer(24);
    chk(irq_o == 1'b1, "R4", "irq after collided transfer", int'(irq_o), 1);
    bus_read(2'd2, d); chk(d == 8'h00, "R7", "status read before done did not arm", int'(d), 0);
    bus_read(2'd1, d); chk(d == 8'hC0, "R9", "both flags, low bits zero", int'(d), 8'hC0);
    bus_read(2'd2, d); chk(d == 8'hA5, "R3", "rx byte after collision", int'(d), 8'hA5);
    bus_read(2'd1, d); chk(d == 8'h00, "R6", "both flags cleared together", int'(d), 0);
    chk(mosi_q.size() == 0, "R2", "all MOSI bytes seen", mosi_q.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule